// File: doc/BRIEF.md
# Unsigned Arithmetic and Logic Unit with Condition Nibble

This block is the purely combinational datapath of a small 16-bit machine that treats every value as a whole number. In a single evaluation it takes an operation code, two register operands and an 8-bit immediate. It produces the value for the destination register, a second value used only when dividing, a hint that tells the surrounding pipeline whether a destination register should be written, and the new contents of the 16-bit condition register.

The condition register holds four live bits: overflow, less-than, greater-than and equal. Only addition, subtraction, multiplication and comparison leave anything in it. Every other operation, including an unrecognised code, produces an all-zero condition word, so the enclosing core can load the output unconditionally after each instruction. Subtraction never wraps: a would-be negative difference becomes zero and raises overflow. Division returns the quotient and the remainder on separate outputs, so the caller can steer them to two registers.

Register reads and writes, instruction fetch and decode, memory and branching belong to the enclosing core.

Top module: `alu_core`

## Requirements
- R1: Opcode 10000 (add) gives the low 16 bits of a+b on res_main. Overflow (flags_word bit 3) is 1 exactly when a+b exceeds 65535. res_we is 1.
- R2: Opcode 10001 (subtract): when b <= a, res_main is a-b and overflow is 0. When b > a, res_main is 0 and overflow is 1. res_we is 1.
- R3: Opcode 10110 (multiply) gives the low 16 bits of a*b. Overflow is 1 exactly when the product exceeds 65535. res_we is 1.
- R4: Opcode 10111 (divide) puts the quotient a/b on res_main and the remainder on res_aux. The flags are all zero and res_we is 1. A divisor of zero gives 0 on both outputs.
- R5: Opcode 11000 shifts a right logically by imm_val. Opcode 11001 shifts a left by imm_val. Any amount of 16 or more gives 0. The flags are zero and res_we is 1.
- R6: Opcodes 11010 (xor), 11011 (or) and 11100 (and) combine a and b bit by bit. Opcode 11101 inverts a and ignores b. The flags are zero and res_we is 1.
- R7: Opcode 11110 (compare) sets exactly one of bit 2 (a<b), bit 1 (a>b) or bit 0 (a==b). Overflow is 0, res_main is 0 and res_we is 0.
- R8: flags_word bits 15 to 4 are always 0. Bit 3 is overflow, bit 2 less-than, bit 1 greater-than and bit 0 equal.
- R9: Any opcode not listed above gives res_main=0, res_aux=0, res_we=0 and flags_word=0.
- R10: res_aux is 0 for every opcode other than divide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 5 | Operation selector |
| opnd_a | input | 16 | First operand (dividend, shift source, inversion source) |
| opnd_b | input | 16 | Second operand |
| imm_val | input | 8 | Shift amount |
| res_main | output | 16 | Primary result (quotient on divide) |
| res_aux | output | 16 | Division remainder, zero otherwise |
| res_we | output | 1 | Destination write hint |
| flags_word | output | 16 | Next condition register value |

## Verification
The bound checker watches these rules on every cycle: the upper flag bits stay clear, a compare raises exactly one relation bit and no write, a clamped subtraction gives zero with overflow, the add overflow bit follows the adder carry, and the remainder output stays silent outside divide. The scoreboard is what shows the actual values. It covers the wrapped sums and products, quotient and remainder pairs, shift amounts at and beyond the word width, the behaviour on a zero divisor, and the zero outputs for unassigned codes. A stream of pseudo-random operations is checked against a model that the bench writes out on its own.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [4:0] {
    OP_ADD = 5'b10000,
    OP_SUB = 5'b10001,
    OP_MUL = 5'b10110,
    OP_DIV = 5'b10111,
    OP_SHR = 5'b11000,
    OP_SHL = 5'b11001,
    OP_XOR = 5'b11010,
    OP_OR  = 5'b11011,
    OP_AND = 5'b11100,
    OP_NOT = 5'b11101,
    OP_CMP = 5'b11110
  } alu_op_e;

  localparam int FLAG_NIB = 4;

  // Field order sets the bit positions: ovf=3, lt=2, gt=1, eq=0
  typedef struct packed {
    logic ovf;
    logic lt;
    logic gt;
    logic eq;
  } cond_nib_t;

endpackage

// File: rtl/alu_arith.sv
module alu_arith #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] sum,
  output logic             sum_ovf,
  output logic [WIDTH-1:0] diff,
  output logic             diff_clamp,
  output logic [WIDTH-1:0] prod,
  output logic             prod_ovf,
  output logic             rel_lt,
  output logic             rel_gt,
  output logic             rel_eq
);

  localparam int PW = 2 * WIDTH;

  function automatic logic [WIDTH:0] wide_add(input logic [WIDTH-1:0] x, input logic [WIDTH-1:0] y);
    return {1'b0, x} + {1'b0, y};
  endfunction

  function automatic logic [PW-1:0] wide_mul(input logic [WIDTH-1:0] x, input logic [WIDTH-1:0] y);
    return {{WIDTH{1'b0}}, x} * {{WIDTH{1'b0}}, y};
  endfunction

  function automatic logic [WIDTH-1:0] floor_sub(input logic [WIDTH-1:0] x, input logic [WIDTH-1:0] y);
    return (y > x) ? '0 : (x - y);
  endfunction

  logic [WIDTH:0] add_full;
  logic [PW-1:0]  mul_full;

  always_comb begin
    add_full   = wide_add(a, b);
    mul_full   = wide_mul(a, b);
    sum        = add_full[WIDTH-1:0];
    sum_ovf    = add_full[WIDTH];
    diff       = floor_sub(a, b);
    diff_clamp = (b > a);
    prod       = mul_full[WIDTH-1:0];
    prod_ovf   = |mul_full[PW-1:WIDTH];
    rel_lt     = (a < b);
    rel_gt     = (a > b);
    rel_eq     = (a == b);
  end

endmodule

// File: rtl/alu_divider.sv
module alu_divider #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic [WIDTH-1:0] quot,
  output logic [WIDTH-1:0] rem,
  output logic             by_zero
);

  function automatic logic [WIDTH-1:0] safe_quot(input logic [WIDTH-1:0] n, input logic [WIDTH-1:0] d);
    return (d == '0) ? '0 : (n / d);
  endfunction

  function automatic logic [WIDTH-1:0] safe_rem(input logic [WIDTH-1:0] n, input logic [WIDTH-1:0] d);
    return (d == '0) ? '0 : (n % d);
  endfunction

  always_comb begin
    by_zero = (divisor == '0);
    quot    = safe_quot(dividend, divisor);
    rem     = safe_rem(dividend, divisor);
  end

endmodule

// File: rtl/alu_bitops.sv
module alu_bitops #(
  parameter int WIDTH   = 16,
  parameter int SHAMT_W = 8
) (
  input  logic [WIDTH-1:0]   a,
  input  logic [WIDTH-1:0]   b,
  input  logic [SHAMT_W-1:0] shamt,
  output logic [WIDTH-1:0]   shr,
  output logic [WIDTH-1:0]   shl,
  output logic [WIDTH-1:0]   bx,
  output logic [WIDTH-1:0]   bo,
  output logic [WIDTH-1:0]   ba,
  output logic [WIDTH-1:0]   bn
);

  function automatic logic [WIDTH-1:0] move_right(input logic [WIDTH-1:0] v, input logic [SHAMT_W-1:0] n);
    return (int'(n) >= WIDTH) ? '0 : (v >> n);
  endfunction

  function automatic logic [WIDTH-1:0] move_left(input logic [WIDTH-1:0] v, input logic [SHAMT_W-1:0] n);
    return (int'(n) >= WIDTH) ? '0 : (v << n);
  endfunction

  always_comb begin
    shr = move_right(a, shamt);
    shl = move_left(a, shamt);
    bx  = a ^ b;
    bo  = a | b;
    ba  = a & b;
    bn  = ~a;
  end

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int IMM_W = 8
) (
  input  logic [4:0]       op_code,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic [IMM_W-1:0] imm_val,
  output logic [WIDTH-1:0] res_main,
  output logic [WIDTH-1:0] res_aux,
  output logic             res_we,
  output logic [WIDTH-1:0] flags_word
);

  localparam int PAD_W = WIDTH - FLAG_NIB;

  logic [WIDTH-1:0] sum, diff, prod, quot, rem;
  logic [WIDTH-1:0] shr, shl, bx, bo, ba, bn;
  logic             carry_out, clamp_hit, mul_ovf, div_zero;
  logic             rel_lt, rel_gt, rel_eq;
  logic             is_cmp;
  cond_nib_t        nib;

  alu_arith #(.WIDTH(WIDTH)) u_arith (
    .a(opnd_a), .b(opnd_b),
    .sum(sum), .sum_ovf(carry_out),
    .diff(diff), .diff_clamp(clamp_hit),
    .prod(prod), .prod_ovf(mul_ovf),
    .rel_lt(rel_lt), .rel_gt(rel_gt), .rel_eq(rel_eq)
  );

  alu_divider #(.WIDTH(WIDTH)) u_div (
    .dividend(opnd_a), .divisor(opnd_b),
    .quot(quot), .rem(rem), .by_zero(div_zero)
  );

  alu_bitops #(.WIDTH(WIDTH), .SHAMT_W(IMM_W)) u_bits (
    .a(opnd_a), .b(opnd_b), .shamt(imm_val),
    .shr(shr), .shl(shl), .bx(bx), .bo(bo), .ba(ba), .bn(bn)
  );

  assign is_cmp = (op_code == OP_CMP);

  always_comb begin
    res_main = '0;
    res_aux  = '0;
    res_we   = 1'b1;
    nib      = '0;
    case (op_code)
      OP_ADD: begin res_main = sum;  nib.ovf = carry_out; end
      OP_SUB: begin res_main = diff; nib.ovf = clamp_hit; end
      OP_MUL: begin res_main = prod; nib.ovf = mul_ovf;   end
      OP_DIV: begin res_main = quot; res_aux = rem;       end
      OP_SHR: res_main = shr;
      OP_SHL: res_main = shl;
      OP_XOR: res_main = bx;
      OP_OR:  res_main = bo;
      OP_AND: res_main = ba;
      OP_NOT: res_main = bn;
      OP_CMP: begin
        res_we = 1'b0;
        nib.lt = rel_lt;
        nib.gt = rel_gt;
        nib.eq = rel_eq;
      end
      default: res_we = 1'b0;
    endcase
    flags_word = {{PAD_W{1'b0}}, nib};
  end

endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk
  import alu_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int IMM_W = 8
) (
  input logic [4:0]       op_code,
  input logic [WIDTH-1:0] opnd_a,
  input logic [WIDTH-1:0] opnd_b,
  input logic [IMM_W-1:0] imm_val,
  input logic [WIDTH-1:0] res_main,
  input logic [WIDTH-1:0] res_aux,
  input logic             res_we,
  input logic [WIDTH-1:0] flags_word,
  input logic             carry_out,
  input logic             clamp_hit,
  input logic             div_zero,
  input logic             is_cmp
);

  logic known;
  logic quiet_op;

  always_comb begin
    known    = !$isunknown({op_code, opnd_a, opnd_b, imm_val});
    quiet_op = (op_code == OP_DIV) || (op_code == OP_SHR) || (op_code == OP_SHL) ||
               (op_code == OP_XOR) || (op_code == OP_OR)  || (op_code == OP_AND) ||
               (op_code == OP_NOT);
    if (known) begin
      // R8
      flag_hi_zero_chk: assert (flags_word[WIDTH-1:FLAG_NIB] == '0)
        else $error("upper flag bits set");
      // R7
      cmp_onehot_chk: assert (!is_cmp || ($countones(flags_word[2:0]) == 1 && !res_we && !flags_word[3]))
        else $error("compare flags malformed");
      // R2
      sub_clamp_chk: assert (!(op_code == OP_SUB && clamp_hit) || (res_main == '0 && flags_word[3]))
        else $error("subtract clamp broken");
      // R1
      add_carry_chk: assert (op_code != OP_ADD || flags_word[3] == carry_out)
        else $error("add overflow mismatch");
      // R4
      div_zero_chk: assert (!(op_code == OP_DIV && div_zero) || (res_main == '0 && res_aux == '0))
        else $error("divide by zero outputs");
      // R10
      aux_quiet_chk: assert (op_code == OP_DIV || res_aux == '0)
        else $error("aux output active");
      // R5 R6
      no_flag_chk: assert (!quiet_op || flags_word == '0)
        else $error("flags not cleared");
    end
  end

endmodule

bind alu_core alu_core_chk #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_chk (.*);

// File: tb/alu_core_tb.sv
module alu_core_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  op_code = '0;
  logic [15:0] opnd_a = '0, opnd_b = '0;
  logic [7:0]  imm_val = '0;
  logic [15:0] res_main, res_aux, flags_word;
  logic        res_we;

  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  alu_core u_dut (
    .op_code(op_code), .opnd_a(opnd_a), .opnd_b(opnd_b), .imm_val(imm_val),
    .res_main(res_main), .res_aux(res_aux), .res_we(res_we), .flags_word(flags_word)
  );

  typedef struct {
    string       tag;
    logic [15:0] m;
    logic [15:0] x;
    logic        w;
    logic [15:0] f;
  } exp_t;

  exp_t sb[$];

  // Reference model written from the requirements with wide integers
  function automatic exp_t model(input logic [4:0] op, input logic [15:0] a,
                                 input logic [15:0] b, input logic [7:0] s, input string tag);
    exp_t e;
    longint la = a, lb = b, t;
    e.tag = tag; e.m = 0; e.x = 0; e.w = 1; e.f = 0;
    case (op)
      5'b10000: begin t = la + lb; e.m = t[15:0]; e.f[3] = (t > 65535); end
      5'b10001: begin if (lb > la) begin e.m = 0; e.f[3] = 1; end else e.m = 16'(la - lb); end
      5'b10110: begin t = la * lb; e.m = t[15:0]; e.f[3] = (t > 65535); end
      5'b10111: begin if (lb != 0) begin e.m = 16'(la / lb); e.x = 16'(la % lb); end end
      5'b11000: e.m = (s >= 16) ? 16'h0 : 16'(la / (64'd1 << s));
      5'b11001: e.m = (s >= 16) ? 16'h0 : 16'((la * (64'd1 << s)) & 64'hFFFF);
      5'b11010: e.m = a ^ b;
      5'b11011: e.m = a | b;
      5'b11100: e.m = a & b;
      5'b11101: e.m = 16'hFFFF - a;
      5'b11110: begin
        e.w = 0;
        if (la < lb) e.f = 16'h0004; else if (la > lb) e.f = 16'h0002; else e.f = 16'h0001;
      end
      default: e.w = 0;
    endcase
    return e;
  endfunction

  task automatic drive(input logic [4:0] op, input logic [15:0] a, input logic [15:0] b,
                       input logic [7:0] s, input string tag);
    @(posedge clk);
    op_code = op; opnd_a = a; opnd_b = b; imm_val = s;
    sb.push_back(model(op, a, b, s, tag));
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      if (sb.size() != 0) begin
        e = sb.pop_front();
        total++;
        if (res_main !== e.m || res_aux !== e.x || res_we !== e.w || flags_word !== e.f) begin
          bad++;
          $display("FAIL %s: got main=%h aux=%h we=%b flags=%h exp main=%h aux=%h we=%b flags=%h",
                   e.tag, res_main, res_aux, res_we, flags_word, e.m, e.x, e.w, e.f);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    logic [4:0] ops [11] = '{5'b10000, 5'b10001, 5'b10110, 5'b10111, 5'b11000,
                             5'b11001, 5'b11010, 5'b11011, 5'b11100, 5'b11101, 5'b11110};
    repeat (3) @(posedge clk);
    rst = 1'b0;
    drive(5'b00000, 0, 0, 0, "R9 reset idle");
    // R1
    drive(5'b10000, 3, 4, 0, "R1 small add");
    drive(5'b10000, 16'hFFFF, 1, 0, "R1 wrap add");
    drive(5'b10000, 16'h8000, 16'h8000, 0, "R1 top bits add");
    // R2
    drive(5'b10001, 10, 3, 0, "R2 plain sub");
    drive(5'b10001, 3, 4, 0, "R2 clamp sub");
    drive(5'b10001, 5, 5, 0, "R2 equal sub");
    // R3
    drive(5'b10110, 10, 100, 0, "R3 mul");
    drive(5'b10110, 16'h0100, 16'h0100, 0, "R3 mul overflow");
    drive(5'b10110, 16'hFFFF, 1, 0, "R3 mul edge");
    // R4
    drive(5'b10111, 17, 5, 0, "R4 div");
    drive(5'b10111, 5, 0, 0, "R4 div by zero");
    drive(5'b10111, 3, 7, 0, "R4 div small");
    // R5
    drive(5'b11000, 16'h8000, 0, 15, "R5 shr 15");
    drive(5'b11000, 16'h8000, 0, 16, "R5 shr 16");
    drive(5'b11000, 16'hFFFF, 0, 255, "R5 shr 255");
    drive(5'b11001, 1, 0, 4, "R5 shl 4");
    drive(5'b11001, 16'hA5A5, 0, 0, "R5 shl 0");
    drive(5'b11001, 16'hFFFF, 0, 16, "R5 shl 16");
    // R6
    drive(5'b11010, 16'hF0F0, 16'hFF00, 0, "R6 xor");
    drive(5'b11011, 16'hF0F0, 16'h0F01, 0, "R6 or");
    drive(5'b11100, 16'hF0F0, 16'h3C3C, 0, "R6 and");
    drive(5'b11101, 16'h1234, 16'hFFFF, 0, "R6 not ignores b");
    drive(5'b10000, 16'hFFFF, 16'hFFFF, 0, "R1 overflow before xor");
    drive(5'b11010, 1, 1, 0, "R6 xor clears flags");
    // R7
    drive(5'b11110, 5, 10, 0, "R7 cmp less");
    drive(5'b11110, 10, 5, 0, "R7 cmp greater");
    drive(5'b11110, 7, 7, 0, "R7 cmp equal");
    // R9 R10
    drive(5'b01010, 16'hFFFF, 16'hFFFF, 9, "R9 undefined 01010");
    drive(5'b11111, 16'h1234, 16'h0001, 1, "R9 undefined 11111");
    drive(5'b00000, 16'hFFFF, 16'hFFFF, 0, "R9 undefined 00000");
    // R8 R10 mixed stream
    for (int i = 0; i < 300; i++) begin
      drive(ops[$urandom_range(10)], 16'($urandom), 16'($urandom_range(3) == 0 ? 0 : $urandom),
            8'($urandom_range(20)), "R8 R10 random mix");
    end
    repeat (3) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule